// File: doc/BRIEF.md
# Adaptive Voltage Level Sequencer

This block programs the supply codes for three reduced operating levels from the code already set for the top level. After a start pulse it reads the top-level code from the voltage controller, converts it to millivolts, and derives one target for level 1 and one shared target for levels 2 and 3. It then searches the code-to-voltage scale for the lowest code that meets each target. Each code is written into the controller's level registers while the controller is switched off, and the controller is switched back on at the end.

All controller traffic goes through a single request/acknowledge register port. The sequencer raises `bus_req_o` with the address, direction and write data. It keeps all of them unchanged until the target returns `bus_ack_i`. The target may stall for any number of cycles, and the sequencer does not advance while it waits. Read data is taken in the cycle in which the acknowledge arrives. Every modifying access is a read of the register followed by a write that changes only the targeted bits.

Top module: `avs_level_seq`

## Requirements
- R1: After reset, `done_o`, `err_o` and `bus_req_o` are low.
- R2: The first access of a sequence is a read of address 0x00. The top-level code is taken from bits 27:22 of the returned word.
- R3: A top-level code of 52 or more is invalid. The sequencer then makes no write, raises `err_o` and pulses `done_o`.
- R4: Code k stands for 747 + floor(35·k/3) mV, for k from 0 to 51. Code 0 is 747 mV and code 51 is 1342 mV.
- R5: A target resolves to the lowest code whose voltage is at least the target. If no code qualifies, it resolves to 51.
- R6: When the top-level voltage is 1000 mV or less, levels 1, 2 and 3 all receive code 22, which is the code for 1000 mV rounded up (1003 mV).
- R7: The level-1 target is the top-level voltage minus 100 mV. The level-2 and level-3 target is the top-level voltage minus 150 mV. Each target is raised to 1000 mV if it falls below that value.
- R8: The writes occur in this order, and each write follows a read of the same address:
  - address 0x00 with bit 30 cleared;
  - address 0x08 with bit 6 set;
  - the level registers at 0x1C, 0x20 and 0x24, for levels 1, 2 and 3;
  - address 0x00 with bit 30 set.
- R9: A level write places the code in bits 21:16 and in bits 27:22. Every other bit keeps the value that was read.
- R10: While `bus_req_o` is high and `bus_ack_i` is low, the request, address, direction and write data hold in the next cycle.
- R11: `done_o` is high for exactly one cycle per sequence. `err_o` keeps its value until the next accepted start.
- R12: A start pulse received while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a sequence when the sequencer is idle |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | Set when the top-level code was invalid; held until the next start |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | Byte address of the register |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Target accepts the access (and read data is valid) |
| bus_rdata_i | input | 32 | Read data, sampled with `bus_ack_i` |

## Verification
The handshake assertion assumes that the target raises `bus_ack_i` only while a request is pending and keeps `bus_rdata_i` stable while it acknowledges. The bench's register model acknowledges only open requests and varies its stall from zero to two cycles. The search assertion assumes that the top-level code does not change during a search. This holds because that code is captured only on the first read and the bench never writes address 0x00 from outside. Start pulses are single cycles, and one of them is placed deliberately inside a running sequence.

// File: rtl/avs_seq_pkg.sv
package avs_seq_pkg;
  localparam int CODE_W    = 6;
  localparam int NUM_CODES = 52;
  localparam int MV_W      = 11;
  localparam int BASE_MV   = 747;
  localparam int FLOOR_MV  = 1000;
  localparam int DROP1_MV  = 100;
  localparam int DROP23_MV = 150;
  localparam int LAST_STEP = 11;

  localparam logic [7:0] ADR_CTRL  = 8'h00;
  localparam logic [7:0] ADR_MODE  = 8'h08;
  localparam logic [7:0] ADR_LVL1  = 8'h1C;
  localparam int         ENA_BIT   = 30;
  localparam int         LOWV_BIT  = 6;
  localparam int         FLD_LO    = 16;
  localparam int         FLD_HI    = 22;

  typedef enum logic [2:0] {ST_IDLE, ST_ACC, ST_CHECK, ST_SEARCH, ST_FIN} seq_st_e;

  // Voltage scale: steps of 35/3 mV from the base, rounded down.
  function automatic logic [MV_W-1:0] code_mv(input logic [CODE_W-1:0] c);
    return MV_W'(BASE_MV + (35 * int'(c)) / 3);
  endfunction
endpackage

// File: rtl/avs_code_search.sv
module avs_code_search
  import avs_seq_pkg::*;
#(
  parameter int NUM = NUM_CODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MV_W-1:0]   target_i,
  output logic              busy_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(NUM - 1);

  logic [CODE_W-1:0] idx;
  logic              hit;

  assign hit = (code_mv(idx) >= target_i) || (idx == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      idx    <= '0;
      code_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      idx    <= '0;
    end else if (busy_o) begin
      if (hit) begin
        busy_o <= 1'b0;
        code_o <= idx;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R5
  roundup_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |->
      ((code_mv(code_o) >= target_i) || (code_o == TOP)) &&
      ((code_o == '0) || (code_mv(code_o - 1'b1) < target_i)));
endmodule

// File: rtl/avs_access_plan.sv
module avs_access_plan
  import avs_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [3:0]        step_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [CODE_W-1:0] code1_i,
  input  logic [CODE_W-1:0] code23_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [DATA_W-1:0] FLD_MASK =
    (DATA_W'((1 << CODE_W) - 1) << FLD_LO) | (DATA_W'((1 << CODE_W) - 1) << FLD_HI);

  function automatic logic [DATA_W-1:0] place(input logic [DATA_W-1:0] v,
                                              input logic [CODE_W-1:0] c);
    return (v & ~FLD_MASK) | (DATA_W'(c) << FLD_LO) | (DATA_W'(c) << FLD_HI);
  endfunction

  assign we_o = step_i[0];

  always_comb begin
    unique case (step_i[3:1])
      3'd0, 3'd5: addr_o = ADDR_W'(ADR_CTRL);
      3'd1:       addr_o = ADDR_W'(ADR_MODE);
      3'd2:       addr_o = ADDR_W'(ADR_LVL1);
      3'd3:       addr_o = ADDR_W'(ADR_LVL1) + ADDR_W'(4);
      3'd4:       addr_o = ADDR_W'(ADR_LVL1) + ADDR_W'(8);
      default:    addr_o = ADDR_W'(ADR_CTRL);
    endcase
  end

  always_comb begin
    case (step_i)
      4'd1:    wdata_o = hold_i & ~(DATA_W'(1) << ENA_BIT);
      4'd3:    wdata_o = hold_i | (DATA_W'(1) << LOWV_BIT);
      4'd5:    wdata_o = place(hold_i, code1_i);
      4'd7,
      4'd9:    wdata_o = place(hold_i, code23_i);
      4'd11:   wdata_o = hold_i | (DATA_W'(1) << ENA_BIT);
      default: wdata_o = '0;
    endcase
  end
endmodule

// File: rtl/avs_level_seq.sv
module avs_level_seq
  import avs_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int NSRCH = 2;

  seq_st_e           st;
  logic [3:0]        step;
  logic [DATA_W-1:0] hold;
  logic [CODE_W-1:0] code0;
  logic              err_q;
  logic              srch_go;
  logic [MV_W-1:0]   v0;
  logic [MV_W-1:0]   tgt   [NSRCH];
  logic [NSRCH-1:0]  sbusy;
  logic [CODE_W-1:0] scode [NSRCH];

  assign v0 = code_mv(code0);

  always_comb begin
    tgt[0] = (v0 > MV_W'(FLOOR_MV + DROP1_MV))  ? v0 - MV_W'(DROP1_MV)  : MV_W'(FLOOR_MV);
    tgt[1] = (v0 > MV_W'(FLOOR_MV + DROP23_MV)) ? v0 - MV_W'(DROP23_MV) : MV_W'(FLOOR_MV);
  end

  assign srch_go = (st == ST_CHECK) && (code0 < CODE_W'(NUM_CODES));

  for (genvar g = 0; g < NSRCH; g++) begin : g_srch
    avs_code_search #(.NUM(NUM_CODES)) u_srch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (srch_go),
      .target_i (tgt[g]),
      .busy_o   (sbusy[g]),
      .code_o   (scode[g])
    );
  end

  avs_access_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plan (
    .step_i   (step),
    .hold_i   (hold),
    .code1_i  (scode[0]),
    .code23_i (scode[1]),
    .addr_o   (bus_addr_o),
    .we_o     (bus_we_o),
    .wdata_o  (bus_wdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      step  <= '0;
      hold  <= '0;
      code0 <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_i) begin
          step  <= '0;
          err_q <= 1'b0;
          st    <= ST_ACC;
        end
        ST_ACC: if (bus_ack_i) begin
          if (!bus_we_o) hold <= bus_rdata_i;
          if (step == 4'd0) begin
            code0 <= bus_rdata_i[FLD_HI +: CODE_W];
            st    <= ST_CHECK;
          end else if (step == 4'(LAST_STEP)) begin
            st <= ST_FIN;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_CHECK: if (srch_go) begin
          st <= ST_SEARCH;
        end else begin
          err_q <= 1'b1;
          st    <= ST_FIN;
        end
        ST_SEARCH: if (sbusy == '0) begin
          step <= 4'd1;
          st   <= ST_ACC;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o = (st == ST_ACC);
  assign done_o    = (st == ST_FIN);
  assign err_o     = err_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                 $stable(bus_we_o) && $stable(bus_wdata_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !(bus_req_o && bus_we_o));
  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i && start_i |=> bus_req_o && $stable(bus_addr_o));
endmodule

// File: tb/avs_level_seq_tb.sv
`timescale 1ns/1ps
module avs_level_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        done, err, req, we, ack = 1'b0;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata = '0;

  int checks = 0, fails = 0;
  int mvt [52];
  logic [31:0] regs [64];
  int          exp_a [$];
  logic [31:0] exp_d [$];
  int wait_cnt = 0, delay = 0;
  logic [7:0]  lat_a;
  logic [31:0] lat_d;
  logic        lat_we;
  int cycles = 0;

  always #2 clk = ~clk;

  avs_level_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done), .err_o(err),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // register model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack) begin
        if (lat_we) begin
          regs[lat_a[7:2]] = lat_d;
          if (exp_a.size() == 0) begin
            chk(1'b0, "R8 R12 unexpected write", {24'h0, lat_a}, 32'h0);
          end else begin
            int ea;
            logic [31:0] ed;
            ea = exp_a.pop_front();
            ed = exp_d.pop_front();
            chk(lat_a == 8'(ea), "R8 write address", {24'h0, lat_a}, ea);
            chk(lat_d == ed, "R9 write data", lat_d, ed);
          end
        end
        ack = 1'b0;
        wait_cnt = 0;
      end else if (req) begin
        if (wait_cnt == delay) begin
          ack = 1'b1;
          rdata = regs[addr[7:2]];
          lat_a = addr; lat_d = wdata; lat_we = we;
          wait_cnt = 0;
          delay = (delay + 1) % 3;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  function automatic int roundup(input int t);
    for (int k = 0; k < 52; k++) if (mvt[k] >= t) return k;
    return 51;
  endfunction

  function automatic logic [31:0] fld(input logic [31:0] x, input int c);
    return (x & ~32'h0FFF_0000) | (32'(c) << 16) | (32'(c) << 22);
  endfunction

  task automatic run_case(input int c0, input logic [31:0] base0, input bit extra);
    int v0, c1, c23, n;
    logic [31:0] e0, snap [10];
    regs[0] = (base0 & ~(32'h3F << 22)) | (32'(c0) << 22);
    regs[2] = 32'hA5A5_0000 ^ 32'(c0);
    regs[7] = 32'hFFFF_FFFF ^ 32'(c0 << 3);
    regs[8] = 32'h1234_5678;
    regs[9] = 32'h0000_0000 | 32'(c0);
    for (int i = 0; i < 10; i++) snap[i] = regs[i];
    c1 = 0; c23 = 0;
    if (c0 < 52) begin
      v0 = mvt[c0];
      // R6 R7 targets
      c1  = roundup((v0 - 100 > 1000) ? v0 - 100 : 1000);
      c23 = roundup((v0 - 150 > 1000) ? v0 - 150 : 1000);
      e0 = regs[0] & ~(32'h1 << 30);
      exp_a.push_back(8'h00); exp_d.push_back(e0);
      exp_a.push_back(8'h08); exp_d.push_back(regs[2] | 32'h40);
      exp_a.push_back(8'h1C); exp_d.push_back(fld(regs[7], c1));
      exp_a.push_back(8'h20); exp_d.push_back(fld(regs[8], c23));
      exp_a.push_back(8'h24); exp_d.push_back(fld(regs[9], c23));
      exp_a.push_back(8'h00); exp_d.push_back(e0 | (32'h1 << 30));
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R11 done seen", {31'h0, done}, 32'h1);
    chk(err == (c0 >= 52), "R3 err at done", {31'h0, err}, {31'h0, c0 >= 52});
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", {31'h0, done}, 32'h0);
    chk(err == (c0 >= 52), "R11 err held", {31'h0, err}, {31'h0, c0 >= 52});
    repeat (20) @(negedge clk);
    chk(exp_a.size() == 0, "R8 all writes seen", exp_a.size(), 0);
    chk(req == 1'b0, "R12 idle after sequence", {31'h0, req}, 32'h0);
    if (c0 >= 52) begin
      for (int i = 0; i < 10; i++)
        chk(regs[i] == snap[i], "R3 registers untouched", regs[i], snap[i]);
    end else begin
      chk(regs[7][21:16] == 6'(c1), "R5 R7 level1 code", regs[7][21:16], c1);
      chk(regs[8][27:22] == 6'(c23), "R5 R7 level2 code", regs[8][27:22], c23);
      chk(regs[0][30] == 1'b1, "R8 enable restored", regs[0], 32'h4000_0000);
    end
    exp_a.delete(); exp_d.delete();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    v = 747;
    for (int k = 0; k < 52; k++) begin
      mvt[k] = v;
      v += (k % 3 == 0) ? 11 : 12;
    end
    for (int i = 0; i < 64; i++) regs[i] = 32'(i) * 32'h0101_0101;
    repeat (3) @(negedge clk);
    // R1
    chk(done == 1'b0 && err == 1'b0 && req == 1'b0, "R1 reset outputs",
        {29'h0, done, err, req}, 32'h0);
    rst_n = 1'b1;
    // R4 scale endpoints as used by the bench model
    chk(mvt[0] == 747 && mvt[51] == 1342 && mvt[22] == 1003, "R4 scale",
        mvt[51], 1342);
    run_case(36, 32'h4000_00FF, 1'b0);   // R7 distinct targets
    run_case(51, 32'hFFFF_FFFF, 1'b0);   // R2 R5 top code
    run_case(30, 32'h0000_0000, 1'b1);   // R12 start while busy
    run_case(22, 32'h4ABC_0001, 1'b0);   // R7 just above floor
    run_case(10, 32'h4000_0000, 1'b0);   // R6 low top level
    run_case(0,  32'h0000_1234, 1'b0);   // R6 lowest code
    run_case(52, 32'h4000_0000, 1'b0);   // R3 first invalid code
    run_case(63, 32'hFFFF_FFFF, 1'b0);   // R3 largest field value
    run_case(40, 32'h4000_0000, 1'b0);   // R10 handshake under stalls
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule